// File: doc/BRIEF.md
# Queue-Depth Probabilistic Congestion Marker

This block sits beside an egress queue. For every departing packet it decides whether the packet should carry the congestion-experienced mark. The decision depends on the queue's byte depth at the moment the packet leaves. Below a lower threshold nothing is marked. Above an upper threshold everything is marked. Between the two thresholds, the chance of marking grows in a straight line with depth, up to a programmable ceiling. A 16-bit linear-feedback shift register supplies the random sample that each decision compares against.

The block only produces the decision. It never holds back or discards a packet, and header rewriting is left to the datapath that consumes the flag. Two free-running counters report how many packets were seen and how many were marked.

The thresholds and the ceiling are written together through one write strobe, so they can be retuned per link speed. Each write starts a serial shift-and-subtract unit that computes the reciprocal of the threshold span. The per-packet path therefore needs only multipliers and no divider.

Top module: `qdepth_ecn_marker`

## Requirements
- R1: A packet whose depth is less than or equal to the lower threshold is never marked.
- R2: Once a reciprocal update has finished, a packet whose depth lies strictly between the thresholds (or equals the upper one) is marked when the 16-bit random sample is below ceiling × (depth − lower) / (upper − lower). Over a long burst the marked fraction follows that line (about 25 %, 50 % and 75 % at the quarter, half and three-quarter points with the ceiling at 1.0).
- R3: A packet whose depth is greater than the upper threshold is always marked.
- R4: After reset the lower threshold is 409600 bytes, the upper threshold is 2097152 bytes and the ceiling is 1.0.
- R5: The ceiling is a 17-bit fraction in which 65536 means 1.0, and written values above 65536 are clamped to 65536. A ceiling of 0 means no packet between the thresholds is marked.
- R6: Each strobe yields exactly one decision, with `mark_vld_o` high in the following cycle. Strobes may arrive every cycle. `mark_o` is only high together with `mark_vld_o`.
- R7: A write with upper ≤ lower sets `cfg_err_o` from the next cycle. While the flag is set, every packet above the lower threshold is marked. A later write with upper > lower clears the flag.
- R8: `seen_cnt_o` advances by one for each decision and `marked_cnt_o` by one for each marked decision, in the same cycle as the decision appears.
- R9: A valid write starts a reciprocal update lasting 33 cycles. Until the update ends, every packet above the lower threshold is marked. A strobe in the same cycle as the write is judged against the previous settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pkt_vld_i | input | 1 | Strobe: a packet departs this cycle |
| qdepth_i | input | 24 | Egress queue depth in bytes at departure |
| cfg_we_i | input | 1 | Write strobe for thresholds and ceiling |
| cfg_lo_i | input | 24 | New lower threshold in bytes |
| cfg_hi_i | input | 24 | New upper threshold in bytes |
| cfg_ceil_i | input | 17 | New ceiling, 65536 = 1.0 |
| mark_vld_o | output | 1 | Decision valid, one cycle after the strobe |
| mark_o | output | 1 | Set the congestion-experienced mark |
| cfg_err_o | output | 1 | Upper threshold not above lower threshold |
| seen_cnt_o | output | 32 | Packets decided |
| marked_cnt_o | output | 32 | Packets marked |

## Verification
The assertions check, on every cycle, the parts of the behaviour that do not depend on randomness. They cover the silence at or below the lower threshold, certain marking above the upper one, the one-cycle strobe-to-decision timing, the error flag that follows a bad write, and the step of both counters. The linear shape of the probability ramp can only be shown statistically. For that, the bench sends long back-to-back bursts at fixed depths and compares marked fractions against the expected line. Other behaviour is tied to particular sequences: the conservative marking while the reciprocal is being recomputed, the effect of a zero ceiling, and clearing the error with a later good write. Directed scenarios in the bench cover these.

// File: rtl/ecn_marker_pkg.sv
package ecn_marker_pkg;

    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_e;

    // Galois feedback mask for a maximal-length 16-bit sequence
    localparam logic [15:0] LFSR16_MASK = 16'hB400;
    localparam logic [15:0] LFSR16_SEED = 16'hACE1;

endpackage

// File: rtl/ecn_lfsr.sv
module ecn_lfsr #(
    parameter int unsigned   W    = 16,
    parameter logic [W-1:0]  MASK = 16'hB400,
    parameter logic [W-1:0]  SEED = 16'hACE1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         step_i,
    output logic [W-1:0] value_o
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (step_i) begin
            val_d = (val_q >> 1) ^ (val_q[0] ? MASK : '0);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) val_q <= SEED;
        else         val_q <= val_d;
    end

    assign value_o = val_q;
endmodule

// File: rtl/ecn_recip_div.sv
module ecn_recip_div
    import ecn_marker_pkg::*;
#(
    parameter int unsigned    DW       = 24,
    parameter int unsigned    RS       = 32,
    parameter logic [RS:0]    RST_QUOT = '0
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [DW-1:0] divisor_i,
    output logic          busy_o,
    output logic [RS:0]   quot_o
);
    localparam int unsigned IW = $clog2(RS + 1);

    typedef struct packed {
        div_state_e    st;
        logic [IW-1:0] idx;
        logic [DW-1:0] dv;
        logic [DW-1:0] rem;
        logic [RS:0]   q;
        logic [RS:0]   res;
    } div_t;

    div_t        s_d, s_q;
    logic [DW:0] trial;
    logic [DW:0] diff;
    logic        num_bit;

    always_comb begin
        s_d     = s_q;
        num_bit = (s_q.idx == IW'(RS));
        trial   = {s_q.rem, num_bit};
        diff    = trial - {1'b0, s_q.dv};
        if (s_q.st == DIV_RUN) begin
            if (trial >= {1'b0, s_q.dv}) begin
                s_d.rem        = diff[DW-1:0];
                s_d.q[s_q.idx] = 1'b1;
            end else begin
                s_d.rem = trial[DW-1:0];
            end
            if (s_q.idx == '0) begin
                s_d.st  = DIV_IDLE;
                s_d.res = s_d.q;
            end else begin
                s_d.idx = s_q.idx - 1'b1;
            end
        end
        if (start_i) begin
            s_d.st  = DIV_RUN;
            s_d.idx = IW'(RS);
            s_d.dv  = divisor_i;
            s_d.rem = '0;
            s_d.q   = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q     <= '0;
            s_q.st  <= DIV_IDLE;
            s_q.res <= RST_QUOT;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = (s_q.st == DIV_RUN);
    assign quot_o = s_q.res;
endmodule

// File: rtl/ecn_ramp_prob.sv
module ecn_ramp_prob #(
    parameter int unsigned DW     = 24,
    parameter int unsigned RS     = 32,
    parameter int unsigned FRAC_W = 16
) (
    input  logic [DW-1:0]   excess_i,
    input  logic [RS:0]     recip_i,
    input  logic [FRAC_W:0] ceil_i,
    output logic [FRAC_W:0] prob_o
);
    localparam int unsigned PW = DW + RS + 1;
    localparam logic [PW-1:0] ONE_W = PW'(1) << FRAC_W;

    logic [PW-1:0]         prod;
    logic [PW-1:0]         frac_wide;
    logic [FRAC_W:0]       frac;
    logic [2*FRAC_W+1:0]   scaled;

    always_comb begin
        prod      = {{(RS+1){1'b0}}, excess_i} * {{DW{1'b0}}, recip_i};
        frac_wide = prod >> (RS - FRAC_W);
        frac      = (frac_wide > ONE_W) ? ONE_W[FRAC_W:0] : frac_wide[FRAC_W:0];
        scaled    = {{(FRAC_W+1){1'b0}}, frac} * {{(FRAC_W+1){1'b0}}, ceil_i};
        prob_o    = scaled[2*FRAC_W:FRAC_W];
    end
endmodule

// File: rtl/qdepth_ecn_marker.sv
module qdepth_ecn_marker
    import ecn_marker_pkg::*;
#(
    parameter int unsigned DEPTH_W     = 24,
    parameter int unsigned FRAC_W      = 16,
    parameter int unsigned RECIP_SHIFT = 32,
    parameter int unsigned CNT_W       = 32,
    parameter int unsigned KMIN_RST    = 409600,
    parameter int unsigned KMAX_RST    = 2097152,
    parameter int unsigned CEIL_RST    = 65536
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               pkt_vld_i,
    input  logic [DEPTH_W-1:0] qdepth_i,
    input  logic               cfg_we_i,
    input  logic [DEPTH_W-1:0] cfg_lo_i,
    input  logic [DEPTH_W-1:0] cfg_hi_i,
    input  logic [FRAC_W:0]    cfg_ceil_i,
    output logic               mark_vld_o,
    output logic               mark_o,
    output logic               cfg_err_o,
    output logic [CNT_W-1:0]   seen_cnt_o,
    output logic [CNT_W-1:0]   marked_cnt_o
);
    localparam logic [FRAC_W:0] ONE = (FRAC_W+1)'(1) << FRAC_W;
    localparam logic [RECIP_SHIFT:0] RECIP_RST = (KMAX_RST > KMIN_RST) ?
        (RECIP_SHIFT+1)'((64'd1 << RECIP_SHIFT) / 64'(KMAX_RST - KMIN_RST)) : '0;

    typedef struct packed {
        logic [DEPTH_W-1:0] lo;
        logic [DEPTH_W-1:0] hi;
        logic [FRAC_W:0]    ceil;
        logic               err;
        logic               mark_vld;
        logic               mark;
        logic [CNT_W-1:0]   seen;
        logic [CNT_W-1:0]   marked;
    } mk_state_t;

    mk_state_t            st_d, st_q;
    logic                 div_start;
    logic                 div_busy;
    logic [DEPTH_W-1:0]   span;
    logic [RECIP_SHIFT:0] recip;
    logic [DEPTH_W-1:0]   excess;
    logic [FRAC_W:0]      prob;
    logic [FRAC_W-1:0]    rnd;
    logic [FRAC_W:0]      ceil_in;
    logic                 decide;

    ecn_lfsr #(
        .W    (FRAC_W),
        .MASK (LFSR16_MASK[FRAC_W-1:0]),
        .SEED (LFSR16_SEED[FRAC_W-1:0])
    ) lfsr_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .step_i  (pkt_vld_i),
        .value_o (rnd)
    );

    ecn_recip_div #(
        .DW       (DEPTH_W),
        .RS       (RECIP_SHIFT),
        .RST_QUOT (RECIP_RST)
    ) div_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (div_start),
        .divisor_i (span),
        .busy_o    (div_busy),
        .quot_o    (recip)
    );

    ecn_ramp_prob #(
        .DW     (DEPTH_W),
        .RS     (RECIP_SHIFT),
        .FRAC_W (FRAC_W)
    ) ramp_i (
        .excess_i (excess),
        .recip_i  (recip),
        .ceil_i   (st_q.ceil),
        .prob_o   (prob)
    );

    always_comb begin
        st_d      = st_q;
        span      = cfg_hi_i - cfg_lo_i;
        ceil_in   = (cfg_ceil_i > ONE) ? ONE : cfg_ceil_i;
        div_start = 1'b0;
        if (cfg_we_i) begin
            st_d.lo   = cfg_lo_i;
            st_d.hi   = cfg_hi_i;
            st_d.ceil = ceil_in;
            st_d.err  = (cfg_hi_i <= cfg_lo_i);
            div_start = (cfg_hi_i > cfg_lo_i);
        end

        excess = qdepth_i - st_q.lo;
        if (qdepth_i <= st_q.lo) begin
            decide = 1'b0;
        end else if (st_q.err || (qdepth_i > st_q.hi) || div_busy) begin
            decide = 1'b1;
        end else begin
            decide = ({1'b0, rnd} < prob);
        end

        st_d.mark_vld = pkt_vld_i;
        st_d.mark     = pkt_vld_i & decide;
        st_d.seen     = st_q.seen + CNT_W'(pkt_vld_i);
        st_d.marked   = st_q.marked + CNT_W'(pkt_vld_i & decide);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.lo   <= DEPTH_W'(KMIN_RST);
            st_q.hi   <= DEPTH_W'(KMAX_RST);
            st_q.ceil <= (FRAC_W+1)'(CEIL_RST);
            st_q.err  <= (KMAX_RST <= KMIN_RST);
        end else begin
            st_q <= st_d;
        end
    end

    assign mark_vld_o   = st_q.mark_vld;
    assign mark_o       = st_q.mark;
    assign cfg_err_o    = st_q.err;
    assign seen_cnt_o   = st_q.seen;
    assign marked_cnt_o = st_q.marked;
endmodule

// File: rtl/qdepth_ecn_marker_chk.sv
module qdepth_ecn_marker_chk #(
    parameter int unsigned DEPTH_W  = 24,
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned KMIN_RST = 409600,
    parameter int unsigned KMAX_RST = 2097152
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               pkt_vld_i,
    input logic [DEPTH_W-1:0] qdepth_i,
    input logic               cfg_we_i,
    input logic [DEPTH_W-1:0] cfg_lo_i,
    input logic [DEPTH_W-1:0] cfg_hi_i,
    input logic               mark_vld_o,
    input logic               mark_o,
    input logic               cfg_err_o,
    input logic [CNT_W-1:0]   seen_cnt_o,
    input logic [CNT_W-1:0]   marked_cnt_o
);
    logic [DEPTH_W-1:0] lo_s, hi_s;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            lo_s <= DEPTH_W'(KMIN_RST);
            hi_s <= DEPTH_W'(KMAX_RST);
        end else if (cfg_we_i) begin
            lo_s <= cfg_lo_i;
            hi_s <= cfg_hi_i;
        end
    end

    AST_LOW_NEVER_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pkt_vld_i && qdepth_i <= lo_s) |=> !mark_o); // R1
    AST_HIGH_ALWAYS_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pkt_vld_i && qdepth_i > hi_s && qdepth_i > lo_s) |=> mark_o); // R3
    AST_DECISION_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pkt_vld_i |=> mark_vld_o); // R6
    AST_NO_SPURIOUS_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pkt_vld_i |=> !mark_vld_o); // R6
    AST_MARK_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mark_o |-> mark_vld_o); // R6
    AST_BAD_CFG_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_we_i |=> (cfg_err_o == ($past(cfg_hi_i) <= $past(cfg_lo_i)))); // R7
    AST_SEEN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (seen_cnt_o == $past(seen_cnt_o) + CNT_W'(mark_vld_o))); // R8
    AST_MARKED_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (marked_cnt_o == $past(marked_cnt_o) + CNT_W'(mark_o))); // R8
endmodule

bind qdepth_ecn_marker qdepth_ecn_marker_chk #(
    .DEPTH_W  (DEPTH_W),
    .CNT_W    (CNT_W),
    .KMIN_RST (KMIN_RST),
    .KMAX_RST (KMAX_RST)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pkt_vld_i    (pkt_vld_i),
    .qdepth_i     (qdepth_i),
    .cfg_we_i     (cfg_we_i),
    .cfg_lo_i     (cfg_lo_i),
    .cfg_hi_i     (cfg_hi_i),
    .mark_vld_o   (mark_vld_o),
    .mark_o       (mark_o),
    .cfg_err_o    (cfg_err_o),
    .seen_cnt_o   (seen_cnt_o),
    .marked_cnt_o (marked_cnt_o)
);

// File: tb/qdepth_ecn_marker_tb.sv
module qdepth_ecn_marker_tb_top;
    localparam int DW = 24;
    localparam int CW = 32;
    localparam int NVEC = 8;
    // {depth, expected mark} under the reset settings
    localparam logic [DW:0] VEC [NVEC] = '{
        {24'd0,        1'b0},
        {24'd1,        1'b0},
        {24'd409599,   1'b0},
        {24'd409600,   1'b0},
        {24'd2097153,  1'b1},
        {24'd2097160,  1'b1},
        {24'd3000000,  1'b1},
        {24'd16777215, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pkt_vld = 1'b0;
    logic [DW-1:0] qdepth = '0;
    logic          cfg_we = 1'b0;
    logic [DW-1:0] cfg_lo = '0;
    logic [DW-1:0] cfg_hi = '0;
    logic [16:0]   cfg_ceil = '0;
    logic          mark_vld, mark, cfg_err;
    logic [CW-1:0] seen_cnt, marked_cnt;

    int n_chk = 0;
    int n_bad = 0;
    int exp_seen = 0;
    int exp_marked = 0;

    always #5 clk = ~clk;

    qdepth_ecn_marker dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .pkt_vld_i    (pkt_vld),
        .qdepth_i     (qdepth),
        .cfg_we_i     (cfg_we),
        .cfg_lo_i     (cfg_lo),
        .cfg_hi_i     (cfg_hi),
        .cfg_ceil_i   (cfg_ceil),
        .mark_vld_o   (mark_vld),
        .mark_o       (mark),
        .cfg_err_o    (cfg_err),
        .seen_cnt_o   (seen_cnt),
        .marked_cnt_o (marked_cnt)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_range(input string req, input longint act, input longint lo, input longint hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic write_cfg(input int lo, input int hi, input int ceil_v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_lo = DW'(lo); cfg_hi = DW'(hi); cfg_ceil = 17'(ceil_v);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic single(input int d, output logic m, output logic v);
        @(negedge clk);
        pkt_vld = 1'b1; qdepth = DW'(d);
        @(negedge clk);
        pkt_vld = 1'b0;
        m = mark; v = mark_vld;
        exp_seen++;
        if (mark) exp_marked++;
    endtask

    task automatic burst(input int d, input int n, output int cnt, output bit all_vld);
        cnt = 0; all_vld = 1'b1;
        @(negedge clk);
        pkt_vld = 1'b1; qdepth = DW'(d);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (mark) cnt++;
            if (!mark_vld) all_vld = 1'b0;
        end
        pkt_vld = 1'b0;
        exp_seen += n;
        exp_marked += cnt;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic m, v;
        int cnt;
        bit allv;

        repeat (3) @(negedge clk);
        check("R8 reset seen", seen_cnt, 0);
        check("R8 reset marked", marked_cnt, 0);
        check("R6 reset vld", mark_vld, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 reset err", cfg_err, 0);

        // Table walk, back-to-back strobes under reset thresholds (R4)
        for (int i = 0; i <= NVEC; i++) begin
            @(negedge clk);
            if (i > 0) begin
                check($sformatf("R6 vec%0d vld", i-1), mark_vld, 1);
                check($sformatf("R4 R1 R3 vec%0d mark", i-1), mark, VEC[i-1][0]);
                exp_seen++;
                if (VEC[i-1][0]) exp_marked++;
            end
            if (i < NVEC) begin
                pkt_vld = 1'b1; qdepth = VEC[i][DW:1];
            end else begin
                pkt_vld = 1'b0;
            end
        end
        @(negedge clk);
        check("R6 idle vld", mark_vld, 0);
        check("R8 seen after table", seen_cnt, exp_seen);
        check("R8 marked after table", marked_cnt, exp_marked);

        // Bad configuration
        write_cfg(5000, 5000, 0);
        check("R7 err set", cfg_err, 1);
        single(5000, m, v);
        check("R7 at lower unmarked", m, 0);
        single(5001, m, v);
        check("R7 above lower marked", m, 1);

        // Good configuration, ceiling 0; update window first
        write_cfg(1000, 5096, 0);
        check("R7 err cleared", cfg_err, 0);
        single(3000, m, v);
        check("R9 ramp marked during update", m, 1);
        repeat (40) @(negedge clk);
        single(3000, m, v);
        check("R5 zero ceiling mid", m, 0);
        single(5096, m, v);
        check("R5 zero ceiling at upper", m, 0);
        single(5097, m, v);
        check("R3 above upper", m, 1);
        single(1000, m, v);
        check("R1 at lower", m, 0);
        check("R6 single vld", v, 1);

        // Statistical ramp, ceiling 1.0 written as oversize value (clamped)
        write_cfg(1000, 5096, 100000);
        repeat (40) @(negedge clk);
        burst(2024, 4096, cnt, allv);
        check_range("R2 R5 quarter point", cnt, 1024-320, 1024+320);
        check("R6 burst vld", allv, 1);
        burst(3048, 4096, cnt, allv);
        check_range("R2 half point", cnt, 2048-320, 2048+320);
        burst(4072, 4096, cnt, allv);
        check_range("R2 three-quarter point", cnt, 3072-320, 3072+320);
        write_cfg(1000, 5096, 32768);
        repeat (40) @(negedge clk);
        burst(5096, 4096, cnt, allv);
        check_range("R2 R5 half ceiling at upper", cnt, 2048-320, 2048+320);

        @(negedge clk);
        check("R8 seen final", seen_cnt, exp_seen);
        check("R8 marked final", marked_cnt, exp_marked);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule